// File: doc/BRIEF.md
# Parallel ROM Boot Fetch Engine

This block sits on the device side of a boot path. It accepts a two-word command, one word at a time, on a valid/ready input. From the command it takes the ROM timing, the ROM data width and the start address. It then reads boot code from an external asynchronous parallel ROM and hands the code on as 32-bit words over a valid/ready output stream.

The first command word sets two access delays, both counted in clocks. One delay runs from an address change to output enable. The other runs from chip-select assertion to output enable. The first word also selects an 8-bit or a 16-bit ROM. The second word gives the start location, scaled down by the ROM width. The number of 32-bit words to fetch is taken from an input port at the moment the second word is accepted.

During a fetch the engine holds chip select low. For each read it drives a byte address, waits the programmed delay, and pulses output enable for one clock. It samples the data bus at the end of that pulse and packs the reads into a word, most significant part first. When a word is complete it waits for the consumer to accept it before the next read begins. Chip select is released after the last word is accepted.

Top module: `prom_boot_fetch`

## Requirements
- R1: In the first command word, bits 31:28 must equal 1110, bits 27:11 must be zero and bit 1 must be zero. Bits 10:6 hold the address-to-enable delay X. Bits 5:2 hold the select-to-enable delay Y. Bit 0 selects the ROM width: 0 means 8-bit and 1 means 16-bit. A first word that breaks any of these rules sets `cmd_err`, starts no fetch and leaves the engine waiting for a first word.
- R2: In the second command word, bits 31:20 must be zero and bits 19:0 hold the start field S. A non-zero upper part sets `cmd_err`, starts no fetch and returns the engine to waiting for a first word.
- R3: The first read uses byte address S*4 for an 8-bit ROM and S*2 for a 16-bit ROM. Each later read advances the address by 1 (8-bit) or 2 (16-bit).
- R4: On the first read of a fetch, `rom_oe_n` falls max(X,Y) clocks after `rom_cs_n` falls; with both delays zero the two fall in the same clock.
- R5: On every later read, `rom_oe_n` is low for exactly one clock, X clocks after the address changed. `rom_oe_n` is never low while `rom_cs_n` is high.
- R6: For an 8-bit ROM, four reads at byte addresses B..B+3 form one word. The byte from B goes to bits 31:24 and the byte from B+3 goes to bits 7:0. Data is taken from `rom_data[7:0]`.
- R7: For a 16-bit ROM, two reads form one word, and the first read fills bits 31:16. On each read, `rom_data[15:8]` holds the lower-addressed byte.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `rom_addr` stay unchanged and no read is made.
- R9: Exactly `fetch_words` words are emitted, after which `rom_cs_n` rises. A count of zero starts no fetch and raises no error.
- R10: `cmd_ready` is high exactly when no fetch is running. An accepted first word that is valid clears `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken (engine idle) |
| cmd_data | input | 32 | Command word |
| fetch_words | input | CNT_W | Number of 32-bit words to fetch, sampled with the second word |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_addr | output | 22 | ROM byte address |
| rom_data | input | DATA_W | ROM data bus |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | WORD_W | Packed word |
| cmd_err | output | 1 | Last command was malformed (held until a valid first word) |

## Verification
Two events can coincide. When X is zero, the address change and the output-enable assertion land in the same clock. When both delays are zero, chip select, the first address and output enable all take effect in one clock. The bench sweeps X over {0,1,2,3,7,31} and Y over {0,1,4,15} for both ROM widths, which forces these coincidences. At every clock with output enable low, it measures the distance back to the last address change or the chip-select edge and compares it with X or max(X,Y). Back-pressure is applied on a fixed pattern so that word completion and stall fall in the same clock as the next pending read. The bench checks that the word and the address hold until acceptance.

// File: rtl/prom_boot_pkg.sv
package prom_boot_pkg;

   localparam int CMD_W        = 32;
   localparam int PREFIX_W     = 4;
   localparam logic [PREFIX_W-1:0] CMD_PREFIX = 4'b1110;
   localparam int ADLY_W       = 5;
   localparam int ADLY_LSB     = 6;
   localparam int CDLY_W       = 4;
   localparam int CDLY_LSB     = 2;
   localparam int RSV_LSB      = ADLY_LSB + ADLY_W;
   localparam int RSV_MSB      = CMD_W - PREFIX_W - 1;
   localparam int WSEL_BAD_BIT = 1;
   localparam int WSEL_BIT     = 0;
   localparam int START_W      = 20;

   typedef struct packed {
      logic [ADLY_W-1:0] addr_dly;
      logic [CDLY_W-1:0] cs_dly;
      logic              wide;
   } boot_timing_t;

   typedef enum logic [2:0] {
      ST_HDR,
      ST_EXT,
      ST_WAIT,
      ST_READ,
      ST_EMIT
   } fetch_state_e;

   function automatic logic [ADLY_W-1:0] first_delay(input boot_timing_t t);
      logic [ADLY_W-1:0] c;
      c = ADLY_W'(t.cs_dly);
      return (t.addr_dly > c) ? t.addr_dly : c;
   endfunction

endpackage

// File: rtl/prom_cmd_decode.sv
module prom_cmd_decode
   import prom_boot_pkg::*;
#(
   parameter int ROM_ADDR_W = START_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CMD_W-1:0]      cmd_word_i,
   input  logic                  take_hdr_i,
   input  logic                  take_ext_i,
   output logic                  hdr_ok_o,
   output logic                  ext_ok_o,
   output boot_timing_t          timing_o,
   output logic [ROM_ADDR_W-1:0] start_byte_o,
   output logic                  err_o
);

   if (ROM_ADDR_W < START_W + 2) begin : g_addr_chk
      $error("ROM_ADDR_W too small for a scaled start field");
   end

   boot_timing_t          timing_q;
   logic                  err_q;
   logic [ROM_ADDR_W-1:0] field;

   assign hdr_ok_o = (cmd_word_i[CMD_W-1 -: PREFIX_W] == CMD_PREFIX)
                  && (cmd_word_i[RSV_MSB:RSV_LSB] == '0)
                  && !cmd_word_i[WSEL_BAD_BIT];
   assign ext_ok_o = (cmd_word_i[CMD_W-1:START_W] == '0);

   assign field        = ROM_ADDR_W'(cmd_word_i[START_W-1:0]);
   assign start_byte_o = timing_q.wide ? (field << 1) : (field << 2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timing_q <= '0;
         err_q    <= 1'b0;
      end else begin
         if (take_hdr_i) begin
            err_q <= !hdr_ok_o;
            if (hdr_ok_o) begin
               timing_q.addr_dly <= cmd_word_i[ADLY_LSB +: ADLY_W];
               timing_q.cs_dly   <= cmd_word_i[CDLY_LSB +: CDLY_W];
               timing_q.wide     <= cmd_word_i[WSEL_BIT];
            end
         end else if (take_ext_i && !ext_ok_o) begin
            err_q <= 1'b1;
         end
      end
   end

   assign timing_o = timing_q;
   assign err_o    = err_q;

   assert_err_on_bad_hdr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hdr_i && !hdr_ok_o) |=> err_o);
   assert_err_on_bad_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take_ext_i && !ext_ok_o) |=> err_o);
   assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hdr_i && hdr_ok_o) |=> !err_o);

endmodule

// File: rtl/prom_word_packer.sv
module prom_word_packer #(
   parameter int WORD_W = 32,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wide_i,
   input  logic              sample_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [WORD_W-1:0] word_o,
   output logic              last_o
);

   localparam int NBYTES = WORD_W / 8;
   localparam int IDX_W  = $clog2(NBYTES) + 1;

   if (WORD_W % 16 != 0) begin : g_word_chk
      $error("WORD_W must be a multiple of 16");
   end
   if (DATA_W != 16) begin : g_data_chk
      $error("DATA_W must be 16 (two byte lanes)");
   end

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] step;
   logic [7:0]       hi_b;
   logic [7:0]       lo_b;

   assign step   = wide_i ? IDX_W'(2) : IDX_W'(1);
   assign last_o = (idx_q + step) == IDX_W'(NBYTES);
   assign hi_b   = data_i[DATA_W-1 -: 8];
   assign lo_b   = data_i[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         idx_q <= '0;
      end else if (sample_i) begin
         idx_q <= last_o ? '0 : idx_q + step;
      end
   end

   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      logic hit_first;
      logic hit_second;
      assign hit_first  = (idx_q == IDX_W'(k));
      assign hit_second = wide_i && ((idx_q + IDX_W'(1)) == IDX_W'(k));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_o[WORD_W-1-8*k -: 8] <= '0;
         end else if (sample_i && (hit_first || hit_second)) begin
            word_o[WORD_W-1-8*k -: 8] <= (wide_i && hit_first) ? hi_b : lo_b;
         end
      end
   end

   assert_lane_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < IDX_W'(NBYTES));
   assert_wide_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_i && wide_i) |-> !idx_q[0]);

endmodule

// File: rtl/prom_access_seq.sv
module prom_access_seq
   import prom_boot_pkg::*;
#(
   parameter int ROM_ADDR_W = START_W + 2,
   parameter int CNT_W      = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid_i,
   input  logic                  hdr_ok_i,
   input  logic                  ext_ok_i,
   input  boot_timing_t          timing_i,
   input  logic [ROM_ADDR_W-1:0] start_byte_i,
   input  logic [CNT_W-1:0]      words_i,
   input  logic                  pack_last_i,
   input  logic                  out_ready_i,
   output logic                  cmd_ready_o,
   output logic                  take_hdr_o,
   output logic                  take_ext_o,
   output logic                  fetch_start_o,
   output logic                  cs_n_o,
   output logic                  oe_n_o,
   output logic [ROM_ADDR_W-1:0] addr_o,
   output logic                  sample_o,
   output logic                  out_valid_o
);

   if (CNT_W < 1) begin : g_cnt_chk
      $error("CNT_W must be at least 1");
   end

   fetch_state_e          state_q;
   logic [ADLY_W-1:0]     cnt_q;
   logic [ADLY_W-1:0]     lead_dly;
   logic [ADLY_W-1:0]     gap_dly;
   logic [CNT_W-1:0]      left_q;
   logic [ROM_ADDR_W-1:0] addr_q;
   logic [ROM_ADDR_W-1:0] step;
   logic                  idle;

   assign lead_dly = first_delay(timing_i);
   assign gap_dly  = timing_i.addr_dly;
   assign step     = timing_i.wide ? ROM_ADDR_W'(2) : ROM_ADDR_W'(1);
   assign idle     = (state_q == ST_HDR) || (state_q == ST_EXT);

   assign take_hdr_o    = cmd_valid_i && (state_q == ST_HDR);
   assign take_ext_o    = cmd_valid_i && (state_q == ST_EXT);
   assign fetch_start_o = take_ext_o && ext_ok_i && (words_i != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HDR;
         cnt_q   <= '0;
         left_q  <= '0;
         addr_q  <= '0;
      end else begin
         case (state_q)
            ST_HDR: begin
               if (take_hdr_o && hdr_ok_i) state_q <= ST_EXT;
            end
            ST_EXT: begin
               if (take_ext_o) begin
                  if (fetch_start_o) begin
                     addr_q  <= start_byte_i;
                     left_q  <= words_i;
                     state_q <= (lead_dly == '0) ? ST_READ : ST_WAIT;
                     cnt_q   <= lead_dly - ADLY_W'(1);
                  end else begin
                     state_q <= ST_HDR;
                  end
               end
            end
            ST_WAIT: begin
               if (cnt_q == '0) state_q <= ST_READ;
               else             cnt_q   <= cnt_q - ADLY_W'(1);
            end
            ST_READ: begin
               if (pack_last_i) begin
                  state_q <= ST_EMIT;
               end else begin
                  addr_q  <= addr_q + step;
                  state_q <= (gap_dly == '0) ? ST_READ : ST_WAIT;
                  cnt_q   <= gap_dly - ADLY_W'(1);
               end
            end
            ST_EMIT: begin
               if (out_ready_i) begin
                  if (left_q == CNT_W'(1)) begin
                     state_q <= ST_HDR;
                  end else begin
                     left_q  <= left_q - CNT_W'(1);
                     addr_q  <= addr_q + step;
                     state_q <= (gap_dly == '0) ? ST_READ : ST_WAIT;
                     cnt_q   <= gap_dly - ADLY_W'(1);
                  end
               end
            end
            default: state_q <= ST_HDR;
         endcase
      end
   end

   assign cmd_ready_o = idle;
   assign cs_n_o      = idle;
   assign oe_n_o      = (state_q != ST_READ);
   assign sample_o    = (state_q == ST_READ);
   assign out_valid_o = (state_q == ST_EMIT);
   assign addr_o      = addr_q;

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && !pack_last_i) |=> addr_q == $past(addr_q) + $past(step));
   assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> cnt_q < lead_dly);
   assert_emit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EMIT && !out_ready_i) |=> (state_q == ST_EMIT) && $stable(addr_q));
   assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EMIT && out_ready_i && left_q == CNT_W'(1)) |=> cs_n_o);

endmodule

// File: rtl/prom_boot_fetch.sv
module prom_boot_fetch
   import prom_boot_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int WORD_W = 32,
   parameter int ROM_ADDR_W = START_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic [CMD_W-1:0]      cmd_data,
   input  logic [CNT_W-1:0]      fetch_words,
   output logic                  rom_cs_n,
   output logic                  rom_oe_n,
   output logic [ROM_ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0]     rom_data,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [WORD_W-1:0]     out_data,
   output logic                  cmd_err
);

   if (WORD_W != CMD_W) begin : g_width_chk
      $error("output word width must match the command word width");
   end

   boot_timing_t          timing;
   logic                  hdr_ok;
   logic                  ext_ok;
   logic                  take_hdr;
   logic                  take_ext;
   logic                  fetch_start;
   logic                  sample;
   logic                  pack_last;
   logic [ROM_ADDR_W-1:0] start_byte;

   prom_cmd_decode #(.ROM_ADDR_W(ROM_ADDR_W)) u_decode (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_word_i   (cmd_data),
      .take_hdr_i   (take_hdr),
      .take_ext_i   (take_ext),
      .hdr_ok_o     (hdr_ok),
      .ext_ok_o     (ext_ok),
      .timing_o     (timing),
      .start_byte_o (start_byte),
      .err_o        (cmd_err)
   );

   prom_access_seq #(.ROM_ADDR_W(ROM_ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid_i   (cmd_valid),
      .hdr_ok_i      (hdr_ok),
      .ext_ok_i      (ext_ok),
      .timing_i      (timing),
      .start_byte_i  (start_byte),
      .words_i       (fetch_words),
      .pack_last_i   (pack_last),
      .out_ready_i   (out_ready),
      .cmd_ready_o   (cmd_ready),
      .take_hdr_o    (take_hdr),
      .take_ext_o    (take_ext),
      .fetch_start_o (fetch_start),
      .cs_n_o        (rom_cs_n),
      .oe_n_o        (rom_oe_n),
      .addr_o        (rom_addr),
      .sample_o      (sample),
      .out_valid_o   (out_valid)
   );

   prom_word_packer #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (fetch_start),
      .wide_i   (timing.wide),
      .sample_i (sample),
      .data_i   (rom_data),
      .word_o   (out_data),
      .last_o   (pack_last)
   );

   assert_oe_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n |-> !rom_cs_n);
   assert_err_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> rom_cs_n);
   assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (rom_cs_n && !out_valid));
   assert_stall_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/prom_boot_fetch_tb.sv
module prom_boot_fetch_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_data = '0;
   logic [15:0] fetch_words = '0;
   logic        rom_cs_n;
   logic        rom_oe_n;
   logic [21:0] rom_addr;
   logic [15:0] rom_data;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        cmd_err;

   always #4 clk = ~clk;

   prom_boot_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_data(cmd_data), .fetch_words(fetch_words), .rom_cs_n(rom_cs_n),
      .rom_oe_n(rom_oe_n), .rom_addr(rom_addr), .rom_data(rom_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .cmd_err(cmd_err)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int cur_x = 0, cur_y = 0, cur_wide = 0;
   logic [21:0] exp_start = '0;
   int reads_seen = 0, words_seen = 0, cs_falls = 0;
   int cyc_cs = 0, cyc_addr = 0;
   logic        prev_cs_n = 1'b1;
   logic [21:0] prev_addr = '0;
   logic        stalled = 1'b0;
   logic [31:0] held_data = '0;

   function automatic logic [7:0] fb(input logic [21:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ {2'b0, a[21:16]} ^ 8'h3C;
   endfunction

   always_comb begin
      if (!rom_cs_n && !rom_oe_n)
         rom_data = cur_wide != 0 ? {fb(rom_addr), fb(rom_addr + 22'd1)}
                                  : {8'hA5, fb(rom_addr)};
      else
         rom_data = 16'hDEAD;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: timing, addresses, packing and stall behaviour
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (prev_cs_n && !rom_cs_n) begin
            cs_falls++;
            cyc_cs = cyc; cyc_addr = cyc;
            reads_seen = 0; words_seen = 0;
         end else if (!rom_cs_n && rom_addr != prev_addr) begin
            cyc_addr = cyc;
         end
         if (!rom_oe_n) begin
            chk(!rom_cs_n, "R5 oe inside cs", rom_cs_n, 0);
            chk(rom_addr == exp_start + 22'(reads_seen * (cur_wide != 0 ? 2 : 1)),
                "R3 read address", rom_addr,
                exp_start + 22'(reads_seen * (cur_wide != 0 ? 2 : 1)));
            if (reads_seen == 0)
               chk(cyc - cyc_cs == (cur_x > cur_y ? cur_x : cur_y), "R4 first enable delay",
                   cyc - cyc_cs, cur_x > cur_y ? cur_x : cur_y);
            else
               chk(cyc - cyc_addr == cur_x, "R5 address to enable delay", cyc - cyc_addr, cur_x);
            reads_seen++;
         end
         if (out_valid) begin
            logic [21:0] b;
            logic [31:0] ew;
            chk(rom_oe_n, "R8 no read while word pending", rom_oe_n, 1);
            if (stalled) begin
               chk(out_data == held_data, "R8 data held in stall", out_data, held_data);
               chk(rom_addr == prev_addr, "R8 address held in stall", rom_addr, prev_addr);
            end
            out_ready = (cyc % 3) != 0;
            if (out_ready) begin
               b  = exp_start + 22'(4 * words_seen);
               ew = {fb(b), fb(b + 22'd1), fb(b + 22'd2), fb(b + 22'd3)};
               if (cur_wide != 0) chk(out_data == ew, "R7 halfword packing", out_data, ew);
               else               chk(out_data == ew, "R6 byte packing", out_data, ew);
               words_seen++;
               stalled = 1'b0;
            end else begin
               stalled   = 1'b1;
               held_data = out_data;
            end
         end else begin
            stalled   = 1'b0;
            out_ready = (cyc % 2) != 0;
         end
      end
      prev_cs_n = rom_cs_n;
      prev_addr = rom_addr;
   end

   task automatic send(input logic [31:0] w, input logic [15:0] n);
      @(negedge clk); #1;
      chk(cmd_ready, "R10 ready while idle", cmd_ready, 1);
      cmd_valid   = 1'b1;
      cmd_data    = w;
      fetch_words = n;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   function automatic logic [31:0] hdr(input int x, input int y, input int wide);
      return {4'b1110, 17'd0, 5'(x), 4'(y), 1'b0, 1'(wide)};
   endfunction

   task automatic idle_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic run_fetch(input int x, input int y, input int wide,
                            input logic [19:0] s, input int n);
      int f0;
      cur_x = x; cur_y = y; cur_wide = wide;
      exp_start = wide != 0 ? {1'b0, s, 1'b0} : {s, 2'b00};
      f0 = cs_falls;
      send(hdr(x, y, wide), 16'd0);
      chk(!cmd_err, "R10 error cleared by valid first word", cmd_err, 0);
      send({12'd0, s}, 16'(n));
      do begin
         @(negedge clk); #1;
      end while (!(cs_falls > f0 && rom_cs_n));
      chk(words_seen == n, "R9 word count", words_seen, n);
      chk(reads_seen == n * (wide != 0 ? 2 : 4), "R9 read count", reads_seen,
          n * (wide != 0 ? 2 : 4));
      chk(cmd_ready, "R10 ready after fetch", cmd_ready, 1);
   endtask

   task automatic bad_cmd(input logic [31:0] w0, input bit second, input logic [31:0] w1,
                          input string tag);
      int f0;
      f0 = cs_falls;
      send(w0, 16'd1);
      if (second) send(w1, 16'd1);
      idle_wait(20);
      chk(cmd_err, tag, cmd_err, 1);
      chk(cs_falls == f0 && rom_cs_n, tag, cs_falls - f0, 0);
      chk(cmd_ready, tag, cmd_ready, 1);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int xs[6];
      int ys[4];
      xs = '{0, 1, 2, 3, 7, 31};
      ys = '{0, 1, 4, 15};
      idle_wait(5);
      rst_n = 1'b1;
      idle_wait(1);
      chk(rom_cs_n && rom_oe_n, "R10 reset: cs and oe high", {rom_cs_n, rom_oe_n}, 3);
      chk(!out_valid, "R9 reset: no word", out_valid, 0);
      chk(cmd_ready && !cmd_err, "R10 reset: ready, no error", {cmd_ready, cmd_err}, 2);

      for (int w = 0; w < 2; w++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 4; j++)
               run_fetch(xs[i], ys[j], w, 20'h00100 + 20'(i * 16 + j), 2 + w);

      run_fetch(2, 5, 0, 20'hFFFFF, 1);
      run_fetch(0, 3, 1, 20'hFFFFE, 1);

      bad_cmd(32'hF000_0000, 1'b0, 32'h0, "R1 wrong prefix");
      run_fetch(1, 1, 0, 20'h00010, 1);
      bad_cmd(hdr(1, 1, 0) | 32'h0000_0800, 1'b0, 32'h0, "R1 reserved bit set");
      bad_cmd(hdr(1, 1, 0) | 32'h0000_0002, 1'b0, 32'h0, "R1 width code 2");
      bad_cmd(hdr(2, 2, 1), 1'b1, 32'h0010_0040, "R2 second word upper bits");
      run_fetch(3, 0, 1, 20'h00040, 2);

      begin
         int f0;
         f0 = cs_falls;
         send(hdr(1, 1, 0), 16'd0);
         send(32'h0000_0020, 16'd0);
         idle_wait(20);
         chk(cs_falls == f0 && rom_cs_n, "R9 zero count starts nothing", cs_falls - f0, 0);
         chk(!cmd_err, "R9 zero count is not an error", cmd_err, 0);
      end
      run_fetch(4, 9, 0, 20'h00200, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule